// File: doc/BRIEF.md
# Reset and Clock-Startup Controller

This block produces the internal reset of a small 8-bit microcontroller core and reports how the clock source has been configured. Two things can start a reset. The first is a power-on-reset input, which takes effect at once. The second is an active-low external reset pin. The pin is first passed through a two-flop synchroniser. It must then read low on consecutive clock edges for a minimum count before it is accepted as a reset. A single high sample restarts that count.

Once the last reset cause has gone away, the core reset is held for a start-up delay. The length of the delay depends on the variant, which is chosen by a parameter:
- **Resonator/crystal variant:** a configuration bit chooses a short delay (about 1 ms) or a long delay (about 16 ms).
- **RC/external-clock variant:** the delay is fixed at about 16 µs.

All delays are parameters counted in cycles of the nominal 1 MHz clock, so a bench can shorten them. A clock-select configuration bit records whether the internal RC clock or an external clock pin is in use. In external-clock mode, port bit 3 becomes the clock input. The block tells the port logic so through a registered flag, which changes only while reset is asserted.

Top module: `rst_clk_startup_ctrl`

## Requirements
- R1: While `por_i` is 1, `core_rst_o` is 1 in the same cycle, without waiting for a clock edge.
- R2: After the last clock edge on which a reset cause is sampled, `core_rst_o` stays 1 for exactly the selected delay D cycles. A power-on pulse covering P edges gives a reset lasting P+D cycles. An external pin held low for L edges (L of at least 2) gives a reset lasting L+D-2 cycles, which includes the synchroniser and filter latency.
- R3: A low on `ext_rst_n_i` is accepted only after it has been sampled low on 2 consecutive edges (parameter `LOW_CYCLES`). A low lasting one sample causes no reset.
- R4: One high sample restarts the low count. A pattern of low, high, low (one edge each) causes no reset.
- R5: In the RC/external variant (`XTAL_VARIANT`=0), D is `RC_DLY_CYC` whatever the value of `fuse_long_start_i`.
- R6: In the crystal variant (`XTAL_VARIANT`=1), D is `XTAL_SHORT_CYC` when `fuse_long_start_i`=0 and `XTAL_LONG_CYC` when it is 1.
- R7: `fuse_ext_clk_i`=0 selects the internal RC clock. In that case `pin3_is_clock_o`=0. A value of 1 selects the external clock pin, and `pin3_is_clock_o` becomes 1. In the crystal variant `pin3_is_clock_o` is always 0.
- R8: `pin3_is_clock_o` changes only after an edge at which `core_rst_o` was 1. A change of the fuse input while the core runs has no effect until the next reset.
- R9: `pin4_gpio_o` is 1 in the RC/external variant and 0 in the crystal variant.
- R10: `ready_o` is 1 exactly when `core_rst_o` is 0, from the first cycle after release.
- R11: `status_o` encodes the state: 0 means the core is running, 1 means a cause was sampled at the last edge, and 2 means the start-up delay is counting. The value 3 never occurs.
- R12: A new reset cause that arrives during the delay restarts the full delay. The result is one merged reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected core clock |
| por_i | input | 1 | Power-on reset request, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| fuse_ext_clk_i | input | 1 | Clock-select configuration: 0 internal RC, 1 external pin |
| fuse_long_start_i | input | 1 | Crystal variant: 0 short delay, 1 long delay |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| ready_o | output | 1 | Core released from reset |
| status_o | output | 2 | 0 run, 1 cause held, 2 delay counting |
| pin3_is_clock_o | output | 1 | Port bit 3 is taken as the clock input |
| pin4_gpio_o | output | 1 | Port bit 4 is available as general I/O |

## Verification
The properties assume that `por_i` is high from time zero for at least one edge. They also assume that the configuration inputs are steady for the length of any reset pulse, so that the latched delay and the clock-select flag each have one well-defined value. The stimulus changes every input one time unit after a rising edge. It changes the configuration bits only while the core is running, and it waits out the longest delay before each new scenario. Every expected reset length therefore follows from the edge-count formulas in R2.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DELAY = 2'd2
    } boot_state_e;

    typedef struct packed {
        logic ext_clk;
        logic long_start;
    } boot_cfg_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int unsigned LOW_CYCLES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(LOW_CYCLES + 1);

    logic          sync1_q;
    logic          sync2_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_n_i;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (por_i || sync2_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CW'(LOW_CYCLES)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign hit_o = (low_cnt_q == CW'(LOW_CYCLES));

endmodule

// File: rtl/startup_timer.sv
module startup_timer
    import rcs_pkg::*;
#(
    parameter int unsigned DW = 14
) (
    input  logic          clk,
    input  logic          cause_i,
    input  logic [DW-1:0] limit_i,
    output boot_state_e   state_o
);
    boot_state_e   state_q;
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (cause_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else if (state_q != ST_RUN) begin
            if (cnt_q == limit_i) begin
                state_q <= ST_RUN;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                state_q <= ST_DELAY;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
    import rcs_pkg::*;
#(
    parameter bit XTAL_VARIANT = 1'b0
) (
    input  logic clk,
    input  logic load_i,
    input  logic fuse_ext_clk_i,
    input  logic fuse_long_start_i,
    output logic long_start_o,
    output logic pin3_is_clock_o
);
    boot_cfg_t cfg_q;
    logic      pin3_q;

    always_ff @(posedge clk) begin
        if (load_i) begin
            cfg_q  <= '{ext_clk: fuse_ext_clk_i, long_start: fuse_long_start_i};
            pin3_q <= !XTAL_VARIANT && fuse_ext_clk_i;
        end
    end

    assign long_start_o    = cfg_q.long_start;
    assign pin3_is_clock_o = pin3_q;

endmodule

// File: rtl/rst_clk_startup_ctrl.sv
module rst_clk_startup_ctrl
    import rcs_pkg::*;
#(
    parameter bit          XTAL_VARIANT   = 1'b0,
    parameter int unsigned LOW_CYCLES     = 2,
    parameter int unsigned RC_DLY_CYC     = 16,
    parameter int unsigned XTAL_SHORT_CYC = 1000,
    parameter int unsigned XTAL_LONG_CYC  = 16000
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       ext_rst_n_i,
    input  logic       fuse_ext_clk_i,
    input  logic       fuse_long_start_i,
    output logic       core_rst_o,
    output logic       ready_o,
    output logic [1:0] status_o,
    output logic       pin3_is_clock_o,
    output logic       pin4_gpio_o
);
    localparam int unsigned DLY_MAX = max3(RC_DLY_CYC, XTAL_SHORT_CYC, XTAL_LONG_CYC);
    localparam int unsigned DW      = $clog2(DLY_MAX + 1);

    logic          ext_hit;
    logic          long_start;
    logic [DW-1:0] dly_limit;
    boot_state_e   state;

    rst_pin_filter #(.LOW_CYCLES(LOW_CYCLES)) i_filter (
        .clk     (clk),
        .por_i   (por_i),
        .pin_n_i (ext_rst_n_i),
        .hit_o   (ext_hit)
    );

    startup_timer #(.DW(DW)) i_timer (
        .clk     (clk),
        .cause_i (por_i | ext_hit),
        .limit_i (dly_limit),
        .state_o (state)
    );

    clk_src_select #(.XTAL_VARIANT(XTAL_VARIANT)) i_src (
        .clk               (clk),
        .load_i            (core_rst_o),
        .fuse_ext_clk_i    (fuse_ext_clk_i),
        .fuse_long_start_i (fuse_long_start_i),
        .long_start_o      (long_start),
        .pin3_is_clock_o   (pin3_is_clock_o)
    );

    generate
        if (XTAL_VARIANT) begin : g_xtal
            assign dly_limit   = long_start ? DW'(XTAL_LONG_CYC - 1)
                                            : DW'(XTAL_SHORT_CYC - 1);
            assign pin4_gpio_o = 1'b0;
        end else begin : g_rc
            logic unused_long;
            assign unused_long = long_start;
            assign dly_limit   = DW'(RC_DLY_CYC - 1);
            assign pin4_gpio_o = 1'b1;
        end
    endgenerate

    assign core_rst_o = por_i | (state != ST_RUN);
    assign ready_o    = (state == ST_RUN) & ~por_i;
    assign status_o   = state;

endmodule

// File: rtl/rst_clk_startup_chk.sv
module rst_clk_startup_chk (
    input logic       clk,
    input logic       por_i,
    input logic       core_rst_o,
    input logic [1:0] status_o,
    input logic       pin3_is_clock_o
);
    // R1: power-on request forces reset in the same cycle
    assert_por_forces_rst_R1: assert property (@(posedge clk)
        por_i |-> core_rst_o);

    // R8: clock-select flag frozen while the core runs
    assert_pin3_frozen_R8: assert property (@(posedge clk) disable iff (por_i)
        !$past(core_rst_o) |-> $stable(pin3_is_clock_o));

    // R2: a release is always preceded by delay counting
    assert_release_after_delay_R2: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst_o) |-> ($past(status_o) == 2'd2));

    // R11: unused state code never appears
    assert_status_legal_R11: assert property (@(posedge clk) disable iff (por_i)
        status_o != 2'd3);

    // R12: a held cause is never followed directly by running
    assert_hold_not_run_R12: assert property (@(posedge clk) disable iff (por_i)
        (status_o == 2'd1) |=> (status_o != 2'd0));

endmodule

bind rst_clk_startup_ctrl rst_clk_startup_chk i_chk (
    .clk             (clk),
    .por_i           (por_i),
    .core_rst_o      (core_rst_o),
    .status_o        (status_o),
    .pin3_is_clock_o (pin3_is_clock_o)
);

// File: tb/test_rst_clk_startup_ctrl.sv
`timescale 1ns/1ps
module test_rst_clk_startup_ctrl;

    localparam int RC = 12;
    localparam int XS = 20;
    localparam int XL = 33;
    localparam int P  = 3;

    logic clk;
    logic por, pin_n, fext, flong;
    logic por_x, pin_n_x, fext_x, flong_x;
    logic core_rst, ready, pin3, pin4;
    logic core_rst_x, ready_x, pin3_x, pin4_x;
    logic [1:0] status, status_x;

    int checks = 0;
    int errors = 0;
    int rdy_bad = 0;
    bit done = 0;
    int q_rc[$];
    int q_x[$];
    bit in_rc = 0, in_x = 0;
    int len_rc = 0, len_x = 0;

    rst_clk_startup_ctrl #(
        .XTAL_VARIANT(1'b0), .LOW_CYCLES(2), .RC_DLY_CYC(RC),
        .XTAL_SHORT_CYC(XS), .XTAL_LONG_CYC(XL)
    ) i_rst_clk_startup_ctrl (
        .clk(clk), .por_i(por), .ext_rst_n_i(pin_n), .fuse_ext_clk_i(fext),
        .fuse_long_start_i(flong), .core_rst_o(core_rst), .ready_o(ready),
        .status_o(status), .pin3_is_clock_o(pin3), .pin4_gpio_o(pin4)
    );

    rst_clk_startup_ctrl #(
        .XTAL_VARIANT(1'b1), .LOW_CYCLES(2), .RC_DLY_CYC(RC),
        .XTAL_SHORT_CYC(XS), .XTAL_LONG_CYC(XL)
    ) i_rst_clk_startup_ctrl_xtal (
        .clk(clk), .por_i(por_x), .ext_rst_n_i(pin_n_x), .fuse_ext_clk_i(fext_x),
        .fuse_long_start_i(flong_x), .core_rst_o(core_rst_x), .ready_o(ready_x),
        .status_o(status_x), .pin3_is_clock_o(pin3_x), .pin4_gpio_o(pin4_x)
    );

    initial begin
        clk = 1'b1;
        forever #2.5 clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor, RC instance: measures each reset pulse and compares it with the queue
    always @(negedge clk) begin
        if (core_rst === 1'b1) begin
            if (!in_rc) begin in_rc = 1; len_rc = 0; end
            len_rc++;
        end else if (in_rc) begin
            in_rc = 0;
            if (q_rc.size() == 0) check(0, "R2", "unexpected pulse rc", len_rc, 0);
            else begin
                int e;
                e = q_rc.pop_front();
                check(len_rc == e, "R2", "pulse length rc", len_rc, e);
            end
        end
        if (ready !== !core_rst) rdy_bad++;
    end

    // Monitor, crystal instance
    always @(negedge clk) begin
        if (core_rst_x === 1'b1) begin
            if (!in_x) begin in_x = 1; len_x = 0; end
            len_x++;
        end else if (in_x) begin
            in_x = 0;
            if (q_x.size() == 0) check(0, "R6", "unexpected pulse xtal", len_x, 0);
            else begin
                int e;
                e = q_x.pop_front();
                check(len_x == e, "R6", "pulse length xtal", len_x, e);
            end
        end
        if (ready_x !== !core_rst_x) rdy_bad++;
    end

    // Driver tasks: push the expected pulse length, then drive the stimulus
    task automatic pin_low_rc(input int l);
        q_rc.push_back(l + RC - 2);
        @(posedge clk); #1 pin_n = 0;
        repeat (l) @(posedge clk);
        #1 pin_n = 1;
        repeat (l + RC + 8) @(posedge clk);
    endtask

    task automatic por_rc(input int d);
        q_rc.push_back(P + d);
        @(posedge clk); #1 por = 1;
        @(negedge clk);
        check(core_rst == 1'b1, "R1", "reset follows por", core_rst, 1);
        repeat (P) @(posedge clk);
        #1 por = 0;
        repeat (d + 8) @(posedge clk);
    endtask

    task automatic idle_no_reset(input string req);
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(core_rst == 1'b0, req, "no reset after short low", core_rst, 0);
    endtask

    initial begin
        por = 1; pin_n = 1; fext = 0; flong = 0;
        por_x = 1; pin_n_x = 1; fext_x = 0; flong_x = 0;
        q_rc.push_back(P + RC);
        q_x.push_back(P + XS);
        @(negedge clk);
        check(core_rst == 1'b1, "R1", "reset at start rc", core_rst, 1);
        check(ready == 1'b0, "R10", "not ready in reset", ready, 0);
        repeat (P) @(posedge clk);
        #1 por = 0; por_x = 0;
        repeat (XS + 8) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R10", "ready after release", ready, 1);
        check(status == 2'd0, "R11", "status run", status, 0);
        check(pin4 == 1'b1, "R9", "pin4 free rc", pin4, 1);
        check(pin4_x == 1'b0, "R9", "pin4 taken xtal", pin4_x, 0);
        check(pin3 == 1'b0, "R7", "pin3 gpio with internal RC", pin3, 0);

        // R3: one-sample glitch
        @(posedge clk); #1 pin_n = 0;
        @(posedge clk); #1 pin_n = 1;
        idle_no_reset("R3");

        // R4: low, high, low restarts the count
        @(posedge clk); #1 pin_n = 0;
        @(posedge clk); #1 pin_n = 1;
        @(posedge clk); #1 pin_n = 0;
        @(posedge clk); #1 pin_n = 1;
        idle_no_reset("R4");

        // R3 / R2: minimum accepted low
        pin_low_rc(2);

        // R11: status sequence during a long low
        q_rc.push_back(6 + RC - 2);
        @(posedge clk); #1 pin_n = 0;
        repeat (6) @(posedge clk);
        #1 pin_n = 1;
        @(negedge clk);
        check(status == 2'd1, "R11", "status hold", status, 1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(status == 2'd2, "R11", "status delay", status, 2);
        repeat (RC + 4) @(posedge clk);
        @(negedge clk);
        check(status == 2'd0, "R11", "status run again", status, 0);

        // R8: fuse change while running has no effect
        @(posedge clk); #1 fext = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pin3 == 1'b0, "R8", "pin3 frozen while running", pin3, 0);
        pin_low_rc(2);
        @(negedge clk);
        check(pin3 == 1'b1, "R7", "pin3 clock after reset", pin3, 1);

        // R5: long-start fuse ignored by RC variant
        @(posedge clk); #1 flong = 1; fext = 0;
        por_rc(RC);
        @(negedge clk);
        check(pin3 == 1'b0, "R7", "pin3 back to gpio", pin3, 0);

        // R12: second cause inside the delay merges into one pulse
        q_rc.push_back(5 + RC);
        @(posedge clk); #1 pin_n = 0;
        repeat (2) @(posedge clk); #1 pin_n = 1;
        repeat (3) @(posedge clk); #1 pin_n = 0;
        repeat (2) @(posedge clk); #1 pin_n = 1;
        repeat (RC + 16) @(posedge clk);

        // R6: crystal variant delays
        @(posedge clk); #1 flong_x = 1; fext_x = 1;
        q_x.push_back(P + XL);
        @(posedge clk); #1 por_x = 1;
        repeat (P) @(posedge clk);
        #1 por_x = 0;
        repeat (XL + 8) @(posedge clk);
        @(negedge clk);
        check(pin3_x == 1'b0, "R7", "pin3 never clock in xtal variant", pin3_x, 0);
        q_x.push_back(3 + XL - 2);
        @(posedge clk); #1 pin_n_x = 0;
        repeat (3) @(posedge clk);
        #1 pin_n_x = 1;
        repeat (XL + 10) @(posedge clk);
        @(posedge clk); #1 flong_x = 0;
        q_x.push_back(2 + XS - 2);
        @(posedge clk); #1 pin_n_x = 0;
        repeat (2) @(posedge clk);
        #1 pin_n_x = 1;
        repeat (XS + 10) @(posedge clk);

        @(negedge clk);
        check(q_rc.size() == 0, "R2", "all rc pulses seen", q_rc.size(), 0);
        check(q_x.size() == 0, "R6", "all xtal pulses seen", q_x.size(), 0);
        check(rdy_bad == 0, "R10", "ready mirrors release", rdy_bad, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule